// File: doc/BRIEF.md
# Inclusive L2 Snoop Filter

This block is the coherence front end of a private, inclusive second-level cache sitting between the shared interconnect and a first-level cache. Because every line held above is also held here, this block alone watches the interconnect's read (BusRd) and read-for-ownership (BusRdX) snoops and answers them. The L1 never snoops. Each line keeps a three-state MSI code. Each line also keeps two extra bits: `in_up`, which says the L1 holds a copy, and `up_newer`, which says this level is Modified but the L1 holds newer dirty data.

Snoops and L1 notifications arrive on two valid/ready ports. The block handles one operation at a time. If it needs the L1, it issues one request on a valid/ready port and waits for a single-beat response, which may carry data. It then may push one dirty line onto a valid/ready flush port, and only then does it raise the ready of the operation it accepted. A snoop is thereby held on the interconnect until every L1 acknowledgement and every flush is done.

Back-pressure rules:
- An offered operation must stay stable until its ready is seen.
- `l1_req_valid` and `flush_valid` hold their payload until the matching ready is sampled high.
- The L1 response is taken in any cycle in which `l1_rsp_ready` is high.

Tag and data storage are reduced to a direct-mapped model holding one data word per line. Addresses are line addresses: the low bits give the set and the rest give the tag.

Top module: `snoop_filter_l2`

## Requirements
- R1: After reset every line is Invalid and no request, flush or ready is asserted. A snoop of either kind to any address then completes with no L1 request and no flush.
- R2: A BusRd (`snp_excl`=0) that hits a Modified line whose `up_newer` bit is clear flushes the stored data on the line address. No L1 request is made, and the line becomes Shared.
- R3: A BusRd that hits a Modified line with `up_newer` set first sends the L1 a downgrade-recall request (kind code 0) for the line address. It then flushes the data returned in the L1 response, keeps that data and moves to Shared.
- R4: A BusRdX (`snp_excl`=1) that hits a line with `in_up` set sends the L1 a request before any flush. The request is recall-and-invalidate (code 1) when `up_newer` is set and invalidate (code 2) otherwise. The line is flushed if Modified, then becomes Invalid.
- R5: A BusRdX that hits a line whose `in_up` bit is clear sends no L1 request. It flushes only a Modified line and leaves the line Invalid.
- R6: A snoop that misses, or a BusRd that hits a Shared line, completes with no request and no flush and changes nothing.
- R7: A fill notice (`l1_ev_kind` 0) for a non-resident address installs the supplied data as Shared with `in_up` set. On a resident line it only sets `in_up`.
- R8: A fill that displaces a valid line of another tag handles the victim before installing the new line. It back-invalidates the victim in the L1 on the victim's address when `in_up` is set (code 1 if `up_newer`, else code 2), then flushes the victim if it is Modified.
- R9: A write-hit notice (kind 1) to a resident line makes it Modified with `up_newer` and `in_up` set. A write-hit notice to a non-resident line is ignored.
- R10: An evict notice (kind 2) to a resident line clears `in_up`, so a later BusRdX sends no L1 request.
- R11: A writeback notice (kind 3) to a resident line stores the supplied data and clears both `up_newer` and `in_up`. A later BusRd flushes that data without an L1 request.
- R12: `snp_ready`/`l1_ev_ready` rise only after any L1 response and any flush handshake. Requests and flushes hold stable while not ready. When a snoop and a notice are offered together, the snoop is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop offered |
| snp_ready | output | 1 | Snoop completed and accepted |
| snp_excl | input | 1 | 1 = BusRdX, 0 = BusRd |
| snp_addr | input | ADDR_W | Snooped line address |
| l1_ev_valid | input | 1 | L1 notification offered |
| l1_ev_ready | output | 1 | Notification completed and accepted |
| l1_ev_kind | input | 2 | 0 fill, 1 write-hit, 2 evict, 3 writeback |
| l1_ev_addr | input | ADDR_W | Line address of the notification |
| l1_ev_data | input | DATA_W | Fill or writeback data |
| l1_req_valid | output | 1 | Request to L1 valid |
| l1_req_ready | input | 1 | L1 takes the request |
| l1_req_kind | output | 2 | 0 downgrade-recall, 1 recall-and-invalidate, 2 invalidate |
| l1_req_addr | output | ADDR_W | Line address for the L1 request |
| l1_rsp_valid | input | 1 | L1 response valid |
| l1_rsp_ready | output | 1 | Block is waiting for the L1 response |
| l1_rsp_data | input | DATA_W | Recalled data (ignored for invalidate) |
| flush_valid | output | 1 | Flush to the interconnect valid |
| flush_ready | input | 1 | Interconnect takes the flush |
| flush_addr | output | ADDR_W | Flushed line address |
| flush_data | output | DATA_W | Flushed data |

## Verification
The bench pushes random streams of snoops and notices over a few tags sharing each set, with random stalls on the request, response and flush sides. Directed sequences cover the following cases:
- a stale line hit by BusRd; a design that skipped the recall would flush the old data.
- a victim still present above; missing the back-invalidate shows up as an absent request on the victim address.
- a write-hit to an absent line; a design that allocated it would produce a spurious flush on the next snoop.
- a writeback followed by a snoop; keeping `up_newer` set would produce an unneeded recall.
- a snoop and a notice offered in the same cycle; serving the notice first would raise the wrong ready.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} lstate_e;
  typedef enum logic [1:0] {EV_FILL = 2'd0, EV_WHIT = 2'd1, EV_EVICT = 2'd2, EV_WBACK = 2'd3} ev_e;
  typedef enum logic [1:0] {RQ_DOWN = 2'd0, RQ_RCINV = 2'd1, RQ_INV = 2'd2} rq_e;
  typedef enum logic [2:0] {F_IDLE, F_REQ, F_WAIT, F_FLUSH, F_FIN} fsm_e;
endpackage

// File: rtl/sf_line_store.sv
module sf_line_store
  import sf_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  lstate_e           w_st,
  input  logic              w_in_up,
  input  logic              w_newer,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  ridx,
  output lstate_e           r_st,
  output logic              r_in_up,
  output logic              r_newer,
  output logic [TAG_W-1:0]  r_tag,
  output logic [DATA_W-1:0] r_data
);
  lstate_e           st_a    [SETS];
  logic              inup_a  [SETS];
  logic              newer_a [SETS];
  logic [TAG_W-1:0]  tag_a   [SETS];
  logic [DATA_W-1:0] data_a  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        st_a[i]    <= LS_I;
        inup_a[i]  <= 1'b0;
        newer_a[i] <= 1'b0;
        tag_a[i]   <= '0;
        data_a[i]  <= '0;
      end
    end else if (we) begin
      st_a[widx]    <= w_st;
      inup_a[widx]  <= w_in_up;
      newer_a[widx] <= w_newer;
      tag_a[widx]   <= w_tag;
      data_a[widx]  <= w_data;
    end
  end

  assign r_st    = st_a[ridx];
  assign r_in_up = inup_a[ridx];
  assign r_newer = newer_a[ridx];
  assign r_tag   = tag_a[ridx];
  assign r_data  = data_a[ridx];
endmodule

// File: rtl/sf_policy.sv
module sf_policy
  import sf_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              is_snp,
  input  logic              excl,
  input  ev_e               ev,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [DATA_W-1:0] data_in,
  input  lstate_e           e_st,
  input  logic              e_in_up,
  input  logic              e_newer,
  input  logic [TAG_W-1:0]  e_tag,
  input  logic [DATA_W-1:0] e_data,
  output logic              need_up,
  output rq_e               up_kind,
  output logic              need_flush,
  output logic              we,
  output lstate_e           n_st,
  output logic              n_in_up,
  output logic              n_newer,
  output logic [TAG_W-1:0]  n_tag,
  output logic [DATA_W-1:0] n_data
);
  logic hit;

  always_comb begin
    hit        = (e_st != LS_I) && (e_tag == tag_in);
    need_up    = 1'b0;
    up_kind    = e_newer ? RQ_RCINV : RQ_INV;
    need_flush = 1'b0;
    we         = 1'b0;
    n_st       = e_st;
    n_in_up    = e_in_up;
    n_newer    = e_newer;
    n_tag      = e_tag;
    n_data     = e_data;
    if (is_snp) begin
      if (!excl) begin
        if (hit && e_st == LS_M) begin
          need_flush = 1'b1;
          need_up    = e_newer;
          up_kind    = RQ_DOWN;
          we         = 1'b1;
          n_st       = LS_S;
          n_newer    = 1'b0;
        end
      end else if (hit) begin
        need_up    = e_in_up;
        need_flush = (e_st == LS_M);
        we         = 1'b1;
        n_st       = LS_I;
        n_in_up    = 1'b0;
        n_newer    = 1'b0;
      end
    end else begin
      unique case (ev)
        EV_FILL: begin
          we      = 1'b1;
          n_in_up = 1'b1;
          if (!hit) begin
            need_up    = (e_st != LS_I) && e_in_up;
            need_flush = (e_st == LS_M);
            n_st       = LS_S;
            n_newer    = 1'b0;
            n_tag      = tag_in;
            n_data     = data_in;
          end
        end
        EV_WHIT: if (hit) begin
          we      = 1'b1;
          n_st    = LS_M;
          n_newer = 1'b1;
          n_in_up = 1'b1;
        end
        EV_EVICT: if (hit) begin
          we      = 1'b1;
          n_in_up = 1'b0;
        end
        EV_WBACK: if (hit) begin
          we      = 1'b1;
          n_data  = data_in;
          n_newer = 1'b0;
          n_in_up = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_filter_l2.sv
module snoop_filter_l2
  import sf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              l1_ev_valid,
  output logic              l1_ev_ready,
  input  logic [1:0]        l1_ev_kind,
  input  logic [ADDR_W-1:0] l1_ev_addr,
  input  logic [DATA_W-1:0] l1_ev_data,
  output logic              l1_req_valid,
  input  logic              l1_req_ready,
  output logic [1:0]        l1_req_kind,
  output logic [ADDR_W-1:0] l1_req_addr,
  input  logic              l1_rsp_valid,
  output logic              l1_rsp_ready,
  input  logic [DATA_W-1:0] l1_rsp_data,
  output logic              flush_valid,
  input  logic              flush_ready,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  fsm_e              fsm;
  logic              op_snp, op_excl, pend_flush;
  ev_e               op_ev;
  rq_e               rq_q;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  logic              idle;
  logic              cur_snp, cur_excl;
  ev_e               cur_ev;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic [IDX_W-1:0]  idx;

  lstate_e           r_st;
  logic              r_in_up, r_newer;
  logic [TAG_W-1:0]  r_tag;
  logic [DATA_W-1:0] r_data;

  logic              p_need_up, p_need_flush, p_we;
  rq_e               p_kind;
  lstate_e           p_st;
  logic              p_in_up, p_newer;
  logic [TAG_W-1:0]  p_tag;
  logic [DATA_W-1:0] p_data;

  logic              rsp_take, fin_wr, s_we;
  lstate_e           s_st;
  logic              s_in_up, s_newer;
  logic [TAG_W-1:0]  s_tag;
  logic [DATA_W-1:0] s_data;

  // Operation source: live inputs while idle (snoop has priority), captured copy afterwards.
  assign idle     = (fsm == F_IDLE);
  assign cur_snp  = idle ? snp_valid : op_snp;
  assign cur_excl = idle ? snp_excl : op_excl;
  assign cur_ev   = idle ? ev_e'(l1_ev_kind) : op_ev;
  assign cur_addr = idle ? (snp_valid ? snp_addr : l1_ev_addr) : op_addr;
  assign cur_data = idle ? l1_ev_data : op_data;
  assign idx      = cur_addr[IDX_W-1:0];

  sf_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n), .we(s_we), .widx(idx),
    .w_st(s_st), .w_in_up(s_in_up), .w_newer(s_newer), .w_tag(s_tag), .w_data(s_data),
    .ridx(idx), .r_st(r_st), .r_in_up(r_in_up), .r_newer(r_newer), .r_tag(r_tag), .r_data(r_data)
  );

  sf_policy #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_policy (
    .is_snp(cur_snp), .excl(cur_excl), .ev(cur_ev),
    .tag_in(cur_addr[ADDR_W-1:IDX_W]), .data_in(cur_data),
    .e_st(r_st), .e_in_up(r_in_up), .e_newer(r_newer), .e_tag(r_tag), .e_data(r_data),
    .need_up(p_need_up), .up_kind(p_kind), .need_flush(p_need_flush), .we(p_we),
    .n_st(p_st), .n_in_up(p_in_up), .n_newer(p_newer), .n_tag(p_tag), .n_data(p_data)
  );

  // A recall response refreshes the line data before any flush; the final update lands in F_FIN.
  assign rsp_take = (fsm == F_WAIT) && l1_rsp_valid && (rq_q != RQ_INV);
  assign fin_wr   = (fsm == F_FIN) && p_we;
  assign s_we     = rsp_take || fin_wr;
  assign s_st     = fin_wr ? p_st    : r_st;
  assign s_in_up  = fin_wr ? p_in_up : r_in_up;
  assign s_newer  = fin_wr ? p_newer : 1'b0;
  assign s_tag    = fin_wr ? p_tag   : r_tag;
  assign s_data   = fin_wr ? p_data  : l1_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm        <= F_IDLE;
      op_snp     <= 1'b0;
      op_excl    <= 1'b0;
      op_ev      <= EV_FILL;
      op_addr    <= '0;
      op_data    <= '0;
      pend_flush <= 1'b0;
      rq_q       <= RQ_INV;
    end else begin
      unique case (fsm)
        F_IDLE: if (snp_valid || l1_ev_valid) begin
          op_snp     <= cur_snp;
          op_excl    <= cur_excl;
          op_ev      <= cur_ev;
          op_addr    <= cur_addr;
          op_data    <= cur_data;
          pend_flush <= p_need_flush;
          rq_q       <= p_kind;
          if (p_need_up)         fsm <= F_REQ;
          else if (p_need_flush) fsm <= F_FLUSH;
          else                   fsm <= F_FIN;
        end
        F_REQ:   if (l1_req_ready) fsm <= F_WAIT;
        F_WAIT:  if (l1_rsp_valid) fsm <= pend_flush ? F_FLUSH : F_FIN;
        F_FLUSH: if (flush_ready)  fsm <= F_FIN;
        F_FIN:   fsm <= F_IDLE;
        default: fsm <= F_IDLE;
      endcase
    end
  end

  assign l1_req_valid = (fsm == F_REQ);
  assign l1_req_kind  = rq_q;
  assign l1_req_addr  = {r_tag, idx};
  assign l1_rsp_ready = (fsm == F_WAIT);
  assign flush_valid  = (fsm == F_FLUSH);
  assign flush_addr   = {r_tag, idx};
  assign flush_data   = r_data;
  assign snp_ready    = (fsm == F_FIN) && op_snp;
  assign l1_ev_ready  = (fsm == F_FIN) && !op_snp;
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_ready,
  input logic              l1_ev_ready,
  input logic              l1_req_valid,
  input logic              l1_req_ready,
  input logic [1:0]        l1_req_kind,
  input logic [ADDR_W-1:0] l1_req_addr,
  input logic              l1_rsp_valid,
  input logic              l1_rsp_ready,
  input logic              flush_valid,
  input logic              flush_ready,
  input logic [ADDR_W-1:0] flush_addr,
  input logic [DATA_W-1:0] flush_data
);
  // R12: completion, request, response wait and flush are separate phases
  a_r12_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snp_ready, l1_ev_ready, l1_req_valid, l1_rsp_ready, flush_valid}));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid && !l1_req_ready |=> l1_req_valid && $stable(l1_req_addr) && $stable(l1_req_kind));

  a_r12_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && !flush_ready |=> flush_valid && $stable(flush_addr) && $stable(flush_data));

  a_r12_wait_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    l1_rsp_ready && !l1_rsp_valid |=> l1_rsp_ready);

  a_r12_req_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid && l1_req_ready |=> l1_rsp_ready);

  // R4: only the three defined request codes appear
  a_r4_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid |-> l1_req_kind != 2'd3);
endmodule

bind snoop_filter_l2 sf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sf_checker (
  .clk(clk), .rst_n(rst_n), .snp_ready(snp_ready), .l1_ev_ready(l1_ev_ready),
  .l1_req_valid(l1_req_valid), .l1_req_ready(l1_req_ready), .l1_req_kind(l1_req_kind),
  .l1_req_addr(l1_req_addr), .l1_rsp_valid(l1_rsp_valid), .l1_rsp_ready(l1_rsp_ready),
  .flush_valid(flush_valid), .flush_ready(flush_ready), .flush_addr(flush_addr),
  .flush_data(flush_data)
);

// File: tb/test_snoop_filter_l2.sv
module test_snoop_filter_l2;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snp_valid = 0, snp_excl = 0, l1_ev_valid = 0;
  logic [ADDR_W-1:0] snp_addr = '0, l1_ev_addr = '0;
  logic [1:0] l1_ev_kind = '0;
  logic [DATA_W-1:0] l1_ev_data = '0, l1_rsp_data = '0;
  logic l1_req_ready = 0, l1_rsp_valid = 0, flush_ready = 0;
  logic snp_ready, l1_ev_ready, l1_req_valid, l1_rsp_ready, flush_valid;
  logic [1:0] l1_req_kind;
  logic [ADDR_W-1:0] l1_req_addr, flush_addr;
  logic [DATA_W-1:0] flush_data;

  snoop_filter_l2 i_snoop_filter_l2 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  function automatic bit tmo(); return cyc > 150000; endfunction

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: %s", req, msg); end
  endtask

  // Reference model of the lines: state 0=I 1=S 2=M
  logic [1:0]        m_st   [8];
  logic [8:0]        m_tag  [8];
  logic              m_inup [8];
  logic              m_new  [8];
  logic [DATA_W-1:0] m_data [8];

  task automatic run_op(input bit is_snp, input bit excl, input logic [1:0] kind,
                        input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
    logic [2:0] idx = addr[2:0];
    logic [8:0] tg = addr[11:3];
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    bit e_req = 0, e_fl = 0, recall = 0, done = 0;
    logic [1:0] e_kind = 0, a_kind = 0;
    logic [ADDR_W-1:0] line = {m_tag[idx], idx}, a_raddr = 0, a_faddr = 0;
    logic [DATA_W-1:0] rdata = 0, a_fdata = 0, e_fdata;
    int n_req = 0, n_fl = 0, c_req = 0, c_fl = 0, c = 0;
    bit rsp_sent = 0;
    string tag = "R6";
    if (is_snp) begin
      if (!excl) begin
        if (hit && m_st[idx] == 2) begin
          e_fl = 1; e_req = m_new[idx]; e_kind = 0;
          tag = m_new[idx] ? "R3" : "R2";
        end
      end else if (hit) begin
        e_req = m_inup[idx]; e_kind = m_new[idx] ? 2'd1 : 2'd2;
        e_fl = (m_st[idx] == 2);
        tag = m_inup[idx] ? "R4" : "R5";
      end
    end else begin
      case (kind)
        2'd0: begin
          tag = "R7";
          if (!hit && m_st[idx] != 0) begin
            tag = "R8";
            e_req = m_inup[idx]; e_kind = m_new[idx] ? 2'd1 : 2'd2;
            e_fl = (m_st[idx] == 2);
          end
        end
        2'd1: tag = "R9";
        2'd2: tag = "R10";
        default: tag = "R11";
      endcase
    end
    recall = e_req && e_kind != 2;
    @(negedge clk);
    if (is_snp) begin snp_valid = 1; snp_excl = excl; snp_addr = addr; end
    else begin l1_ev_valid = 1; l1_ev_kind = kind; l1_ev_addr = addr; l1_ev_data = data; end
    while (!done && !tmo()) begin
      @(negedge clk); c++;
      if (l1_rsp_valid) l1_rsp_valid = 0;
      l1_req_ready = 0;
      if (l1_req_valid && ($urandom % 2 == 0)) begin
        l1_req_ready = 1; n_req++; c_req = c; a_kind = l1_req_kind; a_raddr = l1_req_addr;
      end
      if (l1_rsp_ready && !rsp_sent && ($urandom % 2 == 0)) begin
        rdata = $urandom; l1_rsp_data = rdata; l1_rsp_valid = 1; rsp_sent = 1;
      end
      flush_ready = 0;
      if (flush_valid && ($urandom % 3 != 0)) begin
        flush_ready = 1; n_fl++; c_fl = c; a_faddr = flush_addr; a_fdata = flush_data;
      end
      if ((is_snp && snp_ready) || (!is_snp && l1_ev_ready)) done = 1;
    end
    @(negedge clk);
    snp_valid = 0; l1_ev_valid = 0; l1_req_ready = 0; flush_ready = 0; l1_rsp_valid = 0;
    e_fdata = recall ? rdata : m_data[idx];
    chk(n_req == int'(e_req) && n_fl == int'(e_fl)
        && (!e_req || (a_kind == e_kind && a_raddr == line))
        && (!e_fl || (a_faddr == line && a_fdata == e_fdata))
        && (!(e_req && e_fl) || c_req < c_fl), tag,
        $sformatf("op snp=%0d x=%0d k=%0d a=%h: req %0d/k%0d/%h fl %0d/%h/%h, expected req %0d/k%0d/%h fl %0d/%h/%h",
                  is_snp, excl, kind, addr, n_req, a_kind, a_raddr, n_fl, a_faddr, a_fdata,
                  e_req, e_kind, line, e_fl, line, e_fdata));
    // model update
    if (is_snp) begin
      if (!excl && hit && m_st[idx] == 2) begin
        if (m_new[idx]) m_data[idx] = rdata;
        m_st[idx] = 1; m_new[idx] = 0;
      end else if (excl && hit) begin
        m_st[idx] = 0; m_inup[idx] = 0; m_new[idx] = 0;
      end
    end else begin
      case (kind)
        2'd0: if (hit) m_inup[idx] = 1;
              else begin m_st[idx] = 1; m_tag[idx] = tg; m_data[idx] = data; m_inup[idx] = 1; m_new[idx] = 0; end
        2'd1: if (hit) begin m_st[idx] = 2; m_new[idx] = 1; m_inup[idx] = 1; end
        2'd2: if (hit) m_inup[idx] = 0;
        default: if (hit) begin m_data[idx] = data; m_new[idx] = 0; m_inup[idx] = 0; end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin
      m_st[i] = 0; m_tag[i] = 0; m_inup[i] = 0; m_new[i] = 0; m_data[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!l1_req_valid && !flush_valid && !snp_ready && !l1_ev_ready && !l1_rsp_ready, "R1",
        $sformatf("after reset req=%0d fl=%0d sr=%0d er=%0d, expected all 0",
                  l1_req_valid, flush_valid, snp_ready, l1_ev_ready));
    run_op(1, 1, 0, 12'h005, 0);                 // R1 snoop to empty cache
    run_op(1, 0, 0, 12'h01d, 0);
    // directed sequence
    run_op(0, 0, 0, 12'h011, 32'h1111_0001);     // R7 fill
    run_op(0, 0, 1, 12'h011, 0);                 // R9 write hit
    run_op(1, 0, 0, 12'h011, 0);                 // R3 recall then flush
    run_op(1, 0, 0, 12'h011, 0);                 // R6 shared line
    run_op(0, 0, 0, 12'h019, 32'h2222_0002);     // R8 victim back-invalidate
    run_op(0, 0, 1, 12'h011, 0);                 // R9 ignored on absent line
    run_op(1, 1, 0, 12'h011, 0);                 // R9 no trace of it
    run_op(0, 0, 1, 12'h019, 0);
    run_op(0, 0, 3, 12'h019, 32'h0000_beef);     // R11 writeback
    run_op(1, 0, 0, 12'h019, 0);                 // R11/R2 flush without recall
    run_op(0, 0, 0, 12'h022, 32'h3333_0003);
    run_op(0, 0, 2, 12'h022, 0);                 // R10 evict
    run_op(1, 1, 0, 12'h022, 0);                 // R10/R5 no request
    run_op(0, 0, 0, 12'h023, 32'h4444_0004);
    run_op(0, 0, 1, 12'h023, 0);
    run_op(1, 1, 0, 12'h023, 0);                 // R4 recall-and-invalidate plus flush
    // R12: snoop and notice offered together, snoop served first
    begin
      bit first_snp = 0, seen = 0;
      @(negedge clk);
      snp_valid = 1; snp_excl = 0; snp_addr = 12'h0ff;
      l1_ev_valid = 1; l1_ev_kind = 0; l1_ev_addr = 12'h007; l1_ev_data = 32'h7777_0007;
      while (!seen && !tmo()) begin
        @(negedge clk);
        if (snp_ready || l1_ev_ready) begin seen = 1; first_snp = snp_ready; end
      end
      chk(first_snp, "R12", $sformatf("first ready snp=%0d, expected 1", first_snp));
      @(negedge clk); snp_valid = 0;
      seen = 0;
      while (!seen && !tmo()) begin
        @(negedge clk);
        if (l1_ev_ready) seen = 1;
      end
      chk(seen && !l1_req_valid && !flush_valid, "R12", $sformatf("notice done=%0d, expected 1", seen));
      @(negedge clk); l1_ev_valid = 0;
      m_st[7] = 1; m_tag[7] = 0; m_data[7] = 32'h7777_0007; m_inup[7] = 1; m_new[7] = 0;
    end
    // constrained random
    for (int n = 0; n < 400 && !tmo(); n++) begin
      logic [ADDR_W-1:0] a = {3'd0, 6'($urandom % 3), 3'($urandom % 8)};
      logic [2:0] ix = a[2:0];
      bit h = (m_st[ix] != 0) && (m_tag[ix] == a[11:3]);
      int r = $urandom % 6;
      if (r == 1) run_op(1, 1, 0, a, 0);
      else if (r == 2 && !(h && m_inup[ix])) run_op(0, 0, 0, a, $urandom);
      else if (r == 3 && h && m_inup[ix]) run_op(0, 0, 1, a, 0);
      else if (r == 4 && h && m_inup[ix] && !m_new[ix]) run_op(0, 0, 2, a, 0);
      else if (r == 5 && h && m_new[ix]) run_op(0, 0, 3, a, $urandom);
      else run_op(1, 0, 0, a, 0);
    end
    if (tmo()) chk(0, "R12", "watchdog expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule